// File: doc/BRIEF.md
# Scan-Port Controller with Debug-Bus Read Bridge

This block is a boundary-scan test access port controller for a chip's debug path. An external probe moves it through the standard sixteen-state control sequence by driving a mode line on each rising edge of the scan clock. Serial data goes in and out least-significant bit first.

It has a 4-bit instruction register, a 32-bit identification register and a 1-bit bypass register. Two private data registers bridge to an internal debug module. The first is an 8-bit address holder. The second is a 64-bit data register that fetches a word from that address over a simple request/acknowledge read interface clocked by the scan clock.

A typical session sets the address instruction and shifts in a register number. It then sets the data instruction and shifts out 64 bits. Those bits carry the word the debug module returned when the controller passed through its capture state.

Top module: `jtag_dbg_tap`

## Requirements
- R1: The controller follows the standard 16-state scan sequence, with the mode line sampled on rising `tap_clk` edges. `tap_rst` high at a rising edge puts it in Test-Logic-Reset. Five consecutive rising edges with the mode line high reach Test-Logic-Reset from any state.
- R2: While in Test-Logic-Reset, the active instruction becomes the identification code 4'h1. A data scan with no instruction load therefore returns the identification value.
- R3: Capture-IR loads 4'hF into the 4-bit instruction shifter, which shifts in and out LSB first. The active instruction changes only on leaving Update-IR (or in Test-Logic-Reset).
- R4: Instruction 4'h1 selects a 32-bit register that captures 32'h000018FF.
- R5: Instruction 4'hF and every code other than 4'h1, 4'h8 and 4'h9 select a 1-bit bypass register that captures 0. Serial output therefore lags serial input by one bit, and the first bit out is 0.
- R6: Instruction 4'h8 selects an 8-bit address register. Capture-DR loads the currently held address. The shifted value is latched, and appears on `dbg_addr`, only on leaving Update-DR; it is held through Pause-DR.
- R7: Under instruction 4'h9, `dbg_req` is high exactly while the controller is in Capture-DR, with `dbg_addr` giving the held address. At all other times `dbg_req` is low.
- R8: Under instruction 4'h9, if `dbg_ack` is high at the rising edge that leaves Capture-DR, the 64-bit shifter loads `dbg_rdata`. Otherwise it loads all zeros.
- R9: `tap_dout` changes only on falling `tap_clk` edges. It is 0 unless the controller is in Shift-IR or Shift-DR.
- R10: All data registers shift LSB first, with the input bit entering at the top of the selected length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tap_clk | input | 1 | Scan clock |
| tap_rst | input | 1 | Active-high reset to Test-Logic-Reset, sampled on rising edge |
| tap_mode | input | 1 | Mode line steering the control sequence |
| tap_din | input | 1 | Serial data in, sampled on rising edge |
| tap_dout | output | 1 | Serial data out, updated on falling edge |
| dbg_req | output | 1 | Read request to the debug module |
| dbg_addr | output | 8 | Held debug address |
| dbg_ack | input | 1 | Read acknowledge from the debug module |
| dbg_rdata | input | 64 | Read data from the debug module |

## Verification
A wrong control state appears on `tap_dout` within the same scan. Either captured constants (4'hF, 32'h000018FF) come back misaligned, or bits show up outside the shift states. A corrupted instruction shows on the next data scan as the wrong length or the wrong captured value. An address register that updates too early is caught on `dbg_addr` while the controller sits in Pause-DR. A capture that ignores the acknowledge is exposed by the 64-bit word returned in the very next shift.

// File: rtl/jtag_dbg_pkg.sv
package jtag_dbg_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS, SEL_IDENT, SEL_ADDR, SEL_DATA
    } dr_sel_e;

    localparam int          INSN_W       = 4;
    localparam logic [3:0]  INSN_IDENT   = 4'h1;
    localparam logic [3:0]  INSN_ADDR    = 4'h8;
    localparam logic [3:0]  INSN_DATA    = 4'h9;
    localparam logic [3:0]  INSN_CAPTURE = 4'hF;
    localparam logic [31:0] IDENT_VALUE  = 32'h0000_18FF;

    function automatic tap_state_e tap_next(input tap_state_e st, input logic m);
        case (st)
            ST_RESET:    return m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     return m ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   return m ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   return m ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_SHIFT: return m ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_EX1:   return m ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: return m ? ST_DR_EX2   : ST_DR_PAUSE;
            ST_DR_EX2:   return m ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   return m ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   return m ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   return m ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_SHIFT: return m ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_EX1:   return m ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: return m ? ST_IR_EX2   : ST_IR_PAUSE;
            ST_IR_EX2:   return m ? ST_IR_UPD   : ST_IR_SHIFT;
            default:     return m ? ST_DR_SEL   : ST_IDLE;
        endcase
    endfunction

    function automatic dr_sel_e insn_decode(input logic [3:0] insn);
        case (insn)
            INSN_IDENT: return SEL_IDENT;
            INSN_ADDR:  return SEL_ADDR;
            INSN_DATA:  return SEL_DATA;
            default:    return SEL_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode,
    output tap_state_e state
);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, mode);
    end

    // Independent count of consecutive high mode samples, saturating at five.
    logic [2:0] high_run;
    always_ff @(posedge clk) begin
        if (rst)              high_run <= 3'd5;
        else if (!mode)       high_run <= 3'd0;
        else if (high_run < 3'd5) high_run <= high_run + 3'd1;
    end

    // R1
    five_high_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (high_run == 3'd5) |-> (state == ST_RESET));

    // R1
    forced_reset_chk: assert property (@(posedge clk)
        rst |=> (state == ST_RESET));

endmodule

// File: rtl/jtag_insn_reg.sv
module jtag_insn_reg
    import jtag_dbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  tap_state_e        state,
    output logic [INSN_W-1:0] insn,
    output logic              shift_lsb
);

    logic [INSN_W-1:0] shifter;

    always_ff @(posedge clk) begin
        if (rst) begin
            shifter <= INSN_CAPTURE;
        end else begin
            case (state)
                ST_IR_CAP:   shifter <= INSN_CAPTURE;
                ST_IR_SHIFT: shifter <= {din, shifter[INSN_W-1:1]};
                default:     shifter <= shifter;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_RESET) insn <= INSN_IDENT;
        else if (state == ST_IR_UPD)  insn <= shifter;
    end

    assign shift_lsb = shifter[0];

    // R2
    reset_loads_ident_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESET) |=> (insn == INSN_IDENT));

    // R3
    insn_only_at_update_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IR_UPD && state != ST_RESET) |=> $stable(insn));

endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
    import jtag_dbg_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 64,
    parameter int          IDENT_W  = 32,
    parameter logic [31:0] IDENT    = IDENT_VALUE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  tap_state_e        state,
    input  logic [INSN_W-1:0] insn,
    input  logic              dbg_ack,
    input  logic [DATA_W-1:0] dbg_rdata,
    output logic              dbg_req,
    output logic [ADDR_W-1:0] dbg_addr,
    output logic              shift_lsb
);

    localparam int SR_W = (DATA_W > IDENT_W) ? ((DATA_W > ADDR_W) ? DATA_W : ADDR_W)
                                              : ((IDENT_W > ADDR_W) ? IDENT_W : ADDR_W);

    dr_sel_e       sel;
    int            top_bit;
    logic [SR_W-1:0] shifter, shifted, captured;

    assign sel = insn_decode(insn);

    always_comb begin
        case (sel)
            SEL_IDENT: top_bit = IDENT_W - 1;
            SEL_ADDR:  top_bit = ADDR_W - 1;
            SEL_DATA:  top_bit = DATA_W - 1;
            default:   top_bit = 0;
        endcase
    end

    always_comb begin
        shifted          = shifter >> 1;
        shifted[top_bit] = din;
    end

    always_comb begin
        captured = '0;
        case (sel)
            SEL_IDENT: captured[IDENT_W-1:0] = IDENT[IDENT_W-1:0];
            SEL_ADDR:  captured[ADDR_W-1:0]  = dbg_addr;
            SEL_DATA:  if (dbg_ack) captured[DATA_W-1:0] = dbg_rdata;
            default:   captured = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shifter <= '0;
        end else begin
            case (state)
                ST_DR_CAP:   shifter <= captured;
                ST_DR_SHIFT: shifter <= shifted;
                default:     shifter <= shifter;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                      dbg_addr <= '0;
        else if (state == ST_DR_UPD && sel == SEL_ADDR) dbg_addr <= shifter[ADDR_W-1:0];
    end

    assign dbg_req   = (state == ST_DR_CAP) && (sel == SEL_DATA);
    assign shift_lsb = shifter[0];

    // R7
    req_after_select_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_req) |-> ($past(state) == ST_DR_SEL));

    // R6
    addr_held_chk: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_DR_UPD && insn == INSN_ADDR) |=> $stable(dbg_addr));

    // R8
    no_ack_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !dbg_ack) |=> (shifter == '0));

endmodule

// File: rtl/jtag_dbg_tap.sv
module jtag_dbg_tap
    import jtag_dbg_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 64,
    parameter int IDENT_W = 32
) (
    input  logic              tap_clk,
    input  logic              tap_rst,
    input  logic              tap_mode,
    input  logic              tap_din,
    output logic              tap_dout,
    output logic              dbg_req,
    output logic [ADDR_W-1:0] dbg_addr,
    input  logic              dbg_ack,
    input  logic [DATA_W-1:0] dbg_rdata
);

    tap_state_e        state;
    logic [INSN_W-1:0] insn;
    logic              ir_lsb, dr_lsb;

    jtag_tap_fsm u_fsm (
        .clk   (tap_clk),
        .rst   (tap_rst),
        .mode  (tap_mode),
        .state (state)
    );

    jtag_insn_reg u_ir (
        .clk       (tap_clk),
        .rst       (tap_rst),
        .din       (tap_din),
        .state     (state),
        .insn      (insn),
        .shift_lsb (ir_lsb)
    );

    jtag_dr_bank #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .IDENT_W (IDENT_W)
    ) u_dr (
        .clk       (tap_clk),
        .rst       (tap_rst),
        .din       (tap_din),
        .state     (state),
        .insn      (insn),
        .dbg_ack   (dbg_ack),
        .dbg_rdata (dbg_rdata),
        .dbg_req   (dbg_req),
        .dbg_addr  (dbg_addr),
        .shift_lsb (dr_lsb)
    );

    always_ff @(negedge tap_clk) begin
        if (tap_rst)                    tap_dout <= 1'b0;
        else if (state == ST_IR_SHIFT)  tap_dout <= ir_lsb;
        else if (state == ST_DR_SHIFT)  tap_dout <= dr_lsb;
        else                            tap_dout <= 1'b0;
    end

    // R9
    dout_quiet_chk: assert property (@(posedge tap_clk) disable iff (tap_rst)
        (state != ST_IR_SHIFT && state != ST_DR_SHIFT) |-> (tap_dout == 1'b0));

endmodule

// File: tb/tb_jtag_dbg_tap.sv
module tb_jtag_dbg_tap;

    logic        tck = 1'b0;
    logic        trst = 1'b1;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        req;
    logic [7:0]  addr;
    logic        ack;
    logic [63:0] rdata;
    logic        ack_en = 1'b1;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 tck = ~tck;

    function automatic logic [63:0] pattern(input logic [7:0] a);
        return 64'h0123_4567_89AB_CDEF ^ {8{a}};
    endfunction

    assign ack   = req & ack_en;
    assign rdata = ack ? pattern(addr) : 64'h0;

    jtag_dbg_tap dut (
        .tap_clk   (tck),
        .tap_rst   (trst),
        .tap_mode  (tms),
        .tap_din   (tdi),
        .tap_dout  (tdo),
        .dbg_req   (req),
        .dbg_addr  (addr),
        .dbg_ack   (ack),
        .dbg_rdata (rdata)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        o   = tdo;
        tms = m;
        tdi = d;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] out);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i], o);
            out[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
        idle(1);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] out);
        logic o;
        out = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            out[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
        idle(1);
    endtask

    task automatic do_reset();
        logic o;
        trst = 1'b1;
        step(1, 0, o); step(1, 0, o);
        trst = 1'b0;
        step(0, 0, o);
        idle(1);
    endtask

    task automatic t_reset_state();
        logic [63:0] d;
        logic o;
        do_reset();
        step(0, 0, o);
        // R9: quiet outside shift states
        check("R9 dout idle", {63'h0, o}, 64'h0);
        check("R7 req idle", {63'h0, req}, 64'h0);
        check("R6 addr reset", {56'h0, addr}, 64'h0);
        // R2: default instruction is identification
        scan_dr(32, 64'h0, d);
        check("R2 default ident", d, 64'h0000_18FF);
    endtask

    task automatic t_ir_and_ident();
        logic [3:0] irout;
        logic [63:0] d;
        scan_ir(4'h1, irout);
        // R3: capture value 4'hF
        check("R3 ir capture", {60'h0, irout}, 64'hF);
        // R4 and R10: identification constant, LSB first
        scan_dr(32, 64'hFFFF_FFFF, d);
        check("R4 ident", d, 64'h0000_18FF);
    endtask

    task automatic t_bypass(input logic [3:0] code);
        logic [3:0] irout;
        logic [63:0] d;
        scan_ir(code, irout);
        // R5: one-bit delay, first bit 0
        scan_dr(8, 64'hA5, d);
        check("R5 bypass", d, 64'h4A);
    endtask

    task automatic t_addr_pause();
        logic [3:0] irout;
        logic [63:0] d;
        logic o;
        logic [7:0] val = 8'h3C;
        scan_ir(4'h8, irout);
        scan_dr(8, 64'h02, d);
        check("R6 addr latched", {56'h0, addr}, 64'h02);
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 8; i++) step(i == 7, val[i], o);
        step(0, 0, o); step(0, 0, o);
        // R6: still old value in Pause-DR
        check("R6 held in pause", {56'h0, addr}, 64'h02);
        step(1, 0, o); step(1, 0, o); step(0, 0, o);
        idle(1);
        check("R6 updated", {56'h0, addr}, 64'h3C);
        // R6: capture returns held address
        scan_dr(8, 64'h02, d);
        check("R6 capture readback", d, 64'h3C);
        check("R6 rewrite", {56'h0, addr}, 64'h02);
    endtask

    task automatic t_data_read();
        logic [3:0] irout;
        logic [63:0] d;
        ack_en = 1'b1;
        scan_ir(4'h9, irout);
        // R8 and R10: word from address 0x02
        scan_dr(64, 64'h0, d);
        check("R8 data ack", d, pattern(8'h02));
        ack_en = 1'b0;
        scan_dr(64, 64'hFFFF_FFFF_FFFF_FFFF, d);
        check("R8 data no ack", d, 64'h0);
        ack_en = 1'b1;
        check("R7 req low after", {63'h0, req}, 64'h0);
    endtask

    task automatic t_req_window();
        logic o;
        int seen = 0;
        // IR is data instruction here
        step(1, 0, o); step(0, 0, o);
        step(0, 0, o);
        // R7: req high while in Capture-DR
        seen = req;
        check("R7 req in capture", seen, 1);
        step(1, 0, o); step(1, 0, o); step(0, 0, o);
        idle(1);
    endtask

    task automatic t_tms_reset();
        logic [3:0] irout;
        logic [63:0] d;
        logic o;
        scan_ir(4'h8, irout);
        for (int i = 0; i < 5; i++) step(1, 0, o);
        step(0, 0, o);
        idle(1);
        // R1: five high mode samples reach reset, restoring identification
        scan_dr(32, 64'h0, d);
        check("R1 five high reset", d, 64'h0000_18FF);
    endtask

    initial begin
        t_reset_state();
        t_ir_and_ident();
        t_bypass(4'hF);
        t_bypass(4'h3);
        t_addr_pause();
        t_data_read();
        t_req_window();
        t_tms_reset();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule